// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between a command issuer and the pins of a four-bank SDRAM. The issuer presents one command (activate, read, write, precharge, refresh) with a bank number and a request strobe. The guard grants the command only when every minimum spacing rule for that bank, and between banks, has been met. A request that is not granted stays pending. The issuer must hold it stable until the grant comes. The command output carries the granted command one cycle later and shows NOP in every other cycle.

Every spacing limit is a parameter in picoseconds. At elaboration each one becomes a whole number of clock cycles: the limit divided by the clock period, rounded up. The guard also holds a refresh interval timer that raises a refresh-request flag. For each open bank it raises a warning flag when the row has been open close to the longest time allowed, so the issuer knows a precharge is due.

With the default 8 ns clock the derived counts are:

| Rule | Cycles |
|------|--------|
| activate to read/write | 3 |
| precharge to activate | 3 |
| activate to precharge, minimum | 6 |
| activate to activate, same bank, and refresh to refresh/activate | 9 |
| activate to activate, different banks | 3 |
| write to precharge | 1 |
| refresh interval | 1954 |
| activate to precharge, maximum | 12500 |

The warning margin is 16 cycles.

Top module: `sdg_cmd_guard`

## Requirements
- R1: Reset state. While reset is high and after it, the command output is NOP (code 0), the refresh flag is low and all warning flags are low. All banks start idle, and the first activate after reset is granted in the cycle it is requested. Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5.
- R2: A read or write to a bank is granted no sooner than 3 cycles after that bank's activate was granted.
- R3: An activate to a bank is granted no sooner than 3 cycles after that bank's precharge was granted.
- R4: A precharge to an open bank is granted no sooner than 6 cycles after that bank's activate.
- R5: Two activates to the same bank are at least 9 cycles apart.
- R6: Activates to two different banks are at least 3 cycles apart.
- R7: Reads and writes to an open bank that has met R2 are granted in back-to-back cycles.
- R8: A precharge is granted no sooner than 1 cycle after a write to the same bank.
- R9: A refresh is held off while any bank is open or inside its precharge-to-activate time. An activate or a second refresh is granted no sooner than 9 cycles after a refresh.
- R10: The refresh flag goes high 1955 cycles after the last refresh grant (or after reset), and it is cleared by a refresh grant.
- R11: The warning flag of an open bank rises when the bank has been active for 12484 cycles, and it falls in the cycle after that bank's precharge.
- R12: A grant is combinational from the request. The command and bank granted appear on the issue outputs in the next cycle. A read or write to an idle bank, or any command that breaks a rule, is never granted while the rule still applies. A precharge to an idle bank is granted and has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe; held until grant |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Requested bank |
| grant | output | 1 | Request accepted this cycle |
| issue_cmd | output | 3 | Command sent to the memory, NOP when idle |
| issue_bank | output | 2 | Bank of the issued command |
| ref_req | output | 1 | Refresh due |
| warn_pre | output | 4 | Per-bank warning that the longest active time is near |

## Verification
Each bank's open/closed state and its elapsed-time counters show at the ports only through the delay of the next grant. A counter that is wrong, or that reloads on the wrong event, moves the grant cycle of the next dependent command by one or more cycles, or loses it altogether. A reference model keeps timestamps of every grant and predicts the exact wait cycle of every request, so such faults appear at the first dependent command. Faults in the refresh timer and in the warning threshold appear as a flag edge one cycle off from its predicted cycle.

// File: rtl/sdg_pkg.sv
`timescale 1ns/1ps
package sdg_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5
    } sdg_cmd_e;

    typedef struct packed {
        logic ok_act;
        logic ok_rw;
        logic ok_pre;
        logic ok_ref;
        logic is_open;
        logic warn;
    } bank_stat_t;

    // round a picosecond limit up to whole clock cycles
    function automatic int unsigned ps_to_cyc(input int unsigned lim_ps,
                                              input int unsigned per_ps);
        return (lim_ps + per_ps - 1) / per_ps;
    endfunction

endpackage

// File: rtl/sdg_bank_tracker.sv
`timescale 1ns/1ps
module sdg_bank_tracker
    import sdg_pkg::*;
#(
    parameter int unsigned RCD_CYC     = 3,
    parameter int unsigned RP_CYC      = 3,
    parameter int unsigned RAS_CYC     = 6,
    parameter int unsigned RC_CYC      = 9,
    parameter int unsigned WR_CYC      = 1,
    parameter int unsigned RASMAX_CYC  = 12500,
    parameter int unsigned WARN_MARGIN = 16,
    parameter int unsigned CW          = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       act_i,
    input  logic       pre_i,
    input  logic       wr_i,
    output bank_stat_t stat_o
);
    localparam logic [CW-1:0] CMAX   = {CW{1'b1}};
    localparam logic [CW-1:0] RCD_C  = CW'(RCD_CYC);
    localparam logic [CW-1:0] RP_C   = CW'(RP_CYC);
    localparam logic [CW-1:0] RAS_C  = CW'(RAS_CYC);
    localparam logic [CW-1:0] RC_C   = CW'(RC_CYC);
    localparam logic [CW-1:0] WR_C   = CW'(WR_CYC);
    localparam logic [CW-1:0] WARN_C = CW'(RASMAX_CYC - WARN_MARGIN);

    logic [CW-1:0] act_cnt, pre_cnt, wr_cnt;
    logic          open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt <= CMAX;
            pre_cnt <= CMAX;
            wr_cnt  <= CMAX;
            open_q  <= 1'b0;
        end else begin
            act_cnt <= act_i ? CW'(1) : ((act_cnt == CMAX) ? act_cnt : act_cnt + 1'b1);
            wr_cnt  <= wr_i  ? CW'(1) : ((wr_cnt  == CMAX) ? wr_cnt  : wr_cnt  + 1'b1);
            if (pre_i && open_q)
                pre_cnt <= CW'(1);
            else if (pre_cnt != CMAX)
                pre_cnt <= pre_cnt + 1'b1;
            if (act_i)
                open_q <= 1'b1;
            else if (pre_i)
                open_q <= 1'b0;
        end
    end

    always_comb begin
        stat_o.is_open = open_q;
        stat_o.ok_act  = !open_q && (pre_cnt >= RP_C) && (act_cnt >= RC_C);
        stat_o.ok_rw   = open_q && (act_cnt >= RCD_C);
        stat_o.ok_pre  = !open_q || ((act_cnt >= RAS_C) && (wr_cnt >= WR_C));
        stat_o.ok_ref  = !open_q && (pre_cnt >= RP_C) && (act_cnt >= RC_C);
        stat_o.warn    = open_q && (act_cnt >= WARN_C);
    end

    // R12
    act_opens_chk: assert property (@(posedge clk) disable iff (rst)
        act_i |=> stat_o.is_open);
    // R11
    warn_needs_open_chk: assert property (@(posedge clk) disable iff (rst)
        stat_o.warn |-> stat_o.is_open);
    // R5
    act_cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        act_i |=> (act_cnt != '0));

endmodule

// File: rtl/sdg_global_tracker.sv
`timescale 1ns/1ps
module sdg_global_tracker #(
    parameter int unsigned RRD_CYC  = 3,
    parameter int unsigned RC_CYC   = 9,
    parameter int unsigned REFI_CYC = 1954,
    parameter int unsigned CW       = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic act_any_i,
    input  logic ref_i,
    output logic rrd_ok_o,
    output logic rc_ok_o,
    output logic ref_req_o
);
    localparam int unsigned TW     = $clog2(REFI_CYC + 1);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW-1:0] RRD_C = CW'(RRD_CYC);
    localparam logic [CW-1:0] RC_C  = CW'(RC_CYC);
    localparam logic [TW-1:0] TLAST = TW'(REFI_CYC - 1);

    logic [CW-1:0] act_any_cnt, ref_cnt;
    logic [TW-1:0] ref_tmr;
    logic          ref_req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_any_cnt <= CMAX;
            ref_cnt     <= CMAX;
            ref_tmr     <= '0;
            ref_req_q   <= 1'b0;
        end else begin
            act_any_cnt <= act_any_i ? CW'(1)
                         : ((act_any_cnt == CMAX) ? act_any_cnt : act_any_cnt + 1'b1);
            ref_cnt     <= ref_i ? CW'(1)
                         : ((ref_cnt == CMAX) ? ref_cnt : ref_cnt + 1'b1);
            if (ref_i) begin
                ref_tmr   <= '0;
                ref_req_q <= 1'b0;
            end else if (ref_tmr == TLAST) begin
                ref_tmr   <= '0;
                ref_req_q <= 1'b1;
            end else begin
                ref_tmr   <= ref_tmr + 1'b1;
            end
        end
    end

    assign rrd_ok_o  = act_any_cnt >= RRD_C;
    assign rc_ok_o   = ref_cnt >= RC_C;
    assign ref_req_o = ref_req_q;

    // R10
    ref_clears_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ref_i |=> !ref_req_o);
    // R9
    ref_blocks_rc_chk: assert property (@(posedge clk) disable iff (rst)
        ref_i |=> !rc_ok_o);

endmodule

// File: rtl/sdg_cmd_guard.sv
`timescale 1ns/1ps
module sdg_cmd_guard
    import sdg_pkg::*;
#(
    parameter int unsigned NBANK       = 4,
    parameter int unsigned CLK_PS      = 8000,
    parameter int unsigned RCD_PS      = 20000,
    parameter int unsigned RP_PS       = 20000,
    parameter int unsigned RAS_PS      = 48000,
    parameter int unsigned RASMAX_PS   = 100000000,
    parameter int unsigned RC_PS       = 68000,
    parameter int unsigned RRD_PS      = 20000,
    parameter int unsigned WR_PS       = 8000,
    parameter int unsigned REFI_PS     = 15625000,
    parameter int unsigned WARN_MARGIN = 16,
    localparam int unsigned BW         = $clog2(NBANK)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [2:0]    req_cmd,
    input  logic [BW-1:0] req_bank,
    output logic          grant,
    output logic [2:0]    issue_cmd,
    output logic [BW-1:0] issue_bank,
    output logic          ref_req,
    output logic [NBANK-1:0] warn_pre
);
    localparam int unsigned RCD_CYC    = ps_to_cyc(RCD_PS, CLK_PS);
    localparam int unsigned RP_CYC     = ps_to_cyc(RP_PS, CLK_PS);
    localparam int unsigned RAS_CYC    = ps_to_cyc(RAS_PS, CLK_PS);
    localparam int unsigned RASMAX_CYC = ps_to_cyc(RASMAX_PS, CLK_PS);
    localparam int unsigned RC_CYC     = ps_to_cyc(RC_PS, CLK_PS);
    localparam int unsigned RRD_CYC    = ps_to_cyc(RRD_PS, CLK_PS);
    localparam int unsigned WR_CYC     = ps_to_cyc(WR_PS, CLK_PS);
    localparam int unsigned REFI_CYC   = ps_to_cyc(REFI_PS, CLK_PS);
    localparam int unsigned CW         = $clog2(RASMAX_CYC + 2) + 1;

    sdg_cmd_e   cmd;
    bank_stat_t stat [NBANK];
    logic [NBANK-1:0] act_ev, pre_ev, wr_ev, ok_ref_v, open_v;
    logic rrd_ok, rc_ok, grant_ok, ref_ev;

    assign cmd = sdg_cmd_e'(req_cmd);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign act_ev[b]   = grant && (cmd == CMD_ACT) && (req_bank == BW'(b));
        assign pre_ev[b]   = grant && (cmd == CMD_PRE) && (req_bank == BW'(b));
        assign wr_ev[b]    = grant && (cmd == CMD_WR)  && (req_bank == BW'(b));
        assign ok_ref_v[b] = stat[b].ok_ref;
        assign open_v[b]   = stat[b].is_open;
        assign warn_pre[b] = stat[b].warn;

        sdg_bank_tracker #(
            .RCD_CYC(RCD_CYC), .RP_CYC(RP_CYC), .RAS_CYC(RAS_CYC),
            .RC_CYC(RC_CYC), .WR_CYC(WR_CYC), .RASMAX_CYC(RASMAX_CYC),
            .WARN_MARGIN(WARN_MARGIN), .CW(CW)
        ) u_bank (
            .clk(clk), .rst(rst),
            .act_i(act_ev[b]), .pre_i(pre_ev[b]), .wr_i(wr_ev[b]),
            .stat_o(stat[b])
        );
    end

    assign ref_ev = grant && (cmd == CMD_REF);

    sdg_global_tracker #(
        .RRD_CYC(RRD_CYC), .RC_CYC(RC_CYC), .REFI_CYC(REFI_CYC), .CW(CW)
    ) u_glob (
        .clk(clk), .rst(rst),
        .act_any_i(|act_ev), .ref_i(ref_ev),
        .rrd_ok_o(rrd_ok), .rc_ok_o(rc_ok), .ref_req_o(ref_req)
    );

    always_comb begin
        case (cmd)
            CMD_ACT: grant_ok = stat[req_bank].ok_act && rrd_ok && rc_ok;
            CMD_RD,
            CMD_WR:  grant_ok = stat[req_bank].ok_rw;
            CMD_PRE: grant_ok = stat[req_bank].ok_pre;
            CMD_REF: grant_ok = (&ok_ref_v) && rc_ok;
            default: grant_ok = 1'b0;
        endcase
    end

    assign grant = req_valid && grant_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_cmd  <= CMD_NOP;
            issue_bank <= '0;
        end else begin
            issue_cmd  <= grant ? req_cmd  : CMD_NOP;
            issue_bank <= grant ? req_bank : '0;
        end
    end

    // R12
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        grant |-> req_valid);
    // R12
    issue_echo_chk: assert property (@(posedge clk) disable iff (rst)
        grant |=> (issue_cmd == $past(req_cmd)) && (issue_bank == $past(req_bank)));
    // R12
    idle_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !grant |=> (issue_cmd == CMD_NOP));
    // R12
    rw_open_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && (cmd == CMD_RD || cmd == CMD_WR)) |-> open_v[req_bank]);
    // R9
    ref_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ref_ev |-> (open_v == '0));
    // R6
    one_act_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_ev));

endmodule

// File: tb/sdg_cmd_guard_tb.sv
`timescale 1ns/1ps
module sdg_cmd_guard_tb_top;
    localparam int NB = 4;
    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 9, T_RRD = 3, T_WR = 1;
    localparam int T_REFI = 1954, T_WARN = 12484;
    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                           PRE = 3'd4, REF = 3'd5;

    logic clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic grant, ref_req;
    logic [2:0] issue_cmd;
    logic [1:0] issue_bank;
    logic [NB-1:0] warn_pre;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    logic [4:0] exp_q[$];

    int lact[NB], lpre[NB], lwr[NB];
    bit opn[NB];
    int lact_any = -1000, lref = -1000;

    always #4 clk = ~clk;

    sdg_cmd_guard dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .grant(grant), .issue_cmd(issue_cmd),
        .issue_bank(issue_bank), .ref_req(ref_req), .warn_pre(warn_pre)
    );

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // monitor: pops the expected issue when the design shows one
    always @(negedge clk) begin
        if (!rst && issue_cmd != NOP) begin
            if (exp_q.size() == 0)
                check(1'b0, "R12 unexpected issue", int'({issue_cmd, issue_bank}), 0);
            else begin
                logic [4:0] e;
                e = exp_q.pop_front();
                check({issue_cmd, issue_bank} == e, "R12 issued command",
                      int'({issue_cmd, issue_bank}), int'(e));
            end
        end
    end

    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int earliest(input logic [2:0] c, input int b);
        int t;
        t = 0;
        case (c)
            ACT: t = mx(mx(lpre[b] + T_RP, lact[b] + T_RC), mx(lact_any + T_RRD, lref + T_RC));
            RD, WR: t = lact[b] + T_RCD;
            PRE: t = opn[b] ? mx(lact[b] + T_RAS, lwr[b] + T_WR) : 0;
            REF: begin
                t = lref + T_RC;
                for (int i = 0; i < NB; i++) t = mx(t, mx(lpre[i] + T_RP, lact[i] + T_RC));
            end
            default: t = 0;
        endcase
        return t;
    endfunction

    // driver: called at a negedge, holds the request until granted
    task automatic do_cmd(input logic [2:0] c, input int b, input string rq);
        int ew, w;
        ew = mx(earliest(c, b) - cyc, 0);
        w = 0;
        req_cmd = c; req_bank = 2'(b); req_valid = 1'b1;
        #1;
        while (!grant && w < 300) begin
            @(negedge clk); #1; w++;
        end
        if (grant) begin
            exp_q.push_back({c, 2'(b)});
            case (c)
                ACT: begin lact[b] = cyc; lact_any = cyc; opn[b] = 1'b1; end
                WR:  lwr[b] = cyc;
                PRE: if (opn[b]) begin lpre[b] = cyc; opn[b] = 1'b0; end
                REF: lref = cyc;
                default: ;
            endcase
        end
        check(grant && w == ew, rq, w, ew);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic hold_check(input logic [2:0] c, input int b, input int n, input string rq);
        int seen;
        seen = 0;
        req_cmd = c; req_bank = 2'(b); req_valid = 1'b1;
        for (int i = 0; i < n; i++) begin
            #1; if (grant) seen++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(seen == 0, rq, seen, 0);
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    initial begin
        int g, a;
        for (int i = 0; i < NB; i++) begin
            lact[i] = -1000; lpre[i] = -1000; lwr[i] = -1000; opn[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(issue_cmd == NOP, "R1 issue in reset", issue_cmd, 0);
        check(ref_req == 1'b0, "R1 ref_req in reset", ref_req, 0);
        check(warn_pre == '0, "R1 warn in reset", warn_pre, 0);
        rst = 1'b0;
        @(negedge clk);
        check(issue_cmd == NOP && ref_req == 1'b0, "R1 idle after reset", issue_cmd, 0);

        do_cmd(ACT, 0, "R1 first activate");
        do_cmd(RD, 0, "R2 act to read");
        do_cmd(WR, 0, "R7 read then write");
        do_cmd(RD, 0, "R7 write then read");
        do_cmd(WR, 0, "R7 back to back");
        do_cmd(PRE, 0, "R8 write to precharge");
        do_cmd(ACT, 1, "R6 act other bank");
        do_cmd(ACT, 2, "R6 act third bank");
        do_cmd(ACT, 0, "R3 precharge to act");
        do_cmd(PRE, 0, "R4 act to precharge");
        do_cmd(ACT, 0, "R5 act to act same bank");
        do_cmd(PRE, 3, "R12 precharge idle bank");
        hold_check(RD, 3, 12, "R12 read to idle bank held");
        hold_check(REF, 0, 12, "R9 refresh with open banks held");
        do_cmd(PRE, 0, "R4 close bank 0");
        do_cmd(PRE, 1, "R4 close bank 1");
        do_cmd(PRE, 2, "R4 close bank 2");
        do_cmd(REF, 0, "R9 refresh after precharge");
        g = lref;
        do_cmd(ACT, 1, "R9 refresh to act");
        do_cmd(PRE, 1, "R4 close bank 1 again");

        // R10 refresh flag timing
        wait_to(g + T_REFI);
        check(ref_req == 1'b0, "R10 flag before interval", ref_req, 0);
        @(negedge clk);
        check(ref_req == 1'b1, "R10 flag at interval", ref_req, 1);
        do_cmd(REF, 0, "R9 refresh to refresh");
        check(ref_req == 1'b0, "R10 flag cleared", ref_req, 0);

        // R11 warning near the longest active time
        do_cmd(ACT, 3, "R11 open bank 3");
        a = lact[3];
        wait_to(a + T_WARN - 1);
        check(warn_pre[3] == 1'b0, "R11 warn early", warn_pre[3], 0);
        @(negedge clk);
        check(warn_pre == 4'b1000, "R11 warn raised", warn_pre, 8);
        do_cmd(PRE, 3, "R11 precharge bank 3");
        check(warn_pre == '0, "R11 warn cleared", warn_pre, 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 all issues seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            check(1'b0, "R12 watchdog", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule